// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block drives the array address of a word-addressed memory during synchronous burst reads. While the address-valid strobe is low and the chip is enabled, it latches a start address. From then on it presents one array address per active clock edge and raises a ready flag while the word on the bus is valid. The burst is either continuous, counting up through the whole array, or a linear wrap of 8, 16 or 32 words. A wrap burst stays inside a group that is aligned to its length.

After reset the sequencer is in asynchronous mode and ignores the strobe. A one-cycle configuration-write pulse switches it to burst operation, and it stays there until the next reset. The burst setup arrives on plain inputs and is captured when a burst starts: the mode, the base wait count and the handshaking enable. Handshaking adds stall cycles around the internal 64-word blocks of the array. A select input picks the clock edge that advances the logic.

Top module: `burst_seq`

## Requirements
- R1: After reset `rdy` is low and `rd_addr` is zero. Until a cycle with `cfg_wr` high has been seen, a start strobe is ignored: `rdy` stays low and `rd_addr` keeps its value.
- R2: When a burst is latched on an active edge, `rd_addr` shows the start address after that edge. `rdy` rises on active edge number T after the latch edge, where T is `cfg_wait` plus any extra from R8. When T is 0, `rdy` rises on the latch edge itself.
- R3: With `cfg_mode` = 0 (continuous), every later active edge with `rdy` high advances `rd_addr` by one. After the all-ones address it rolls over to zero.
- R4: `cfg_mode` = 1, 2 or 3 selects a wrap of 8, 16 or 32 words. The address counts up inside the group aligned to that size and returns from the last address of the group to the first. Example: 8 words from 39h gives 39h..3Fh, then 38h.
- R5: A wrap burst presents at most 128 words. On the edge after the 128th word, `rdy` goes low and `rd_addr` holds until a new burst is latched.
- R6: In continuous mode with `hs_en` set at the start, the word at offset 3Fh of a 64-word block is followed by two edges with `rdy` low and the address held. The next offset-00h address then appears with `rdy` high. Wrap bursts never stall after the first word.
- R7: With `hs_en` clear at the start, the 64-word boundary adds no cycles, and the initial latency is just `cfg_wait`.
- R8: With `hs_en` set, a start offset (address bits 5:0) of 3Dh, 3Eh or 3Fh adds 1, 2 or 3 cycles to the initial latency.
- R9: With `hs_en` set and a start offset of 3Eh or 3Fh, the first 64-word crossing of that burst has no stall.
- R10: `ce_n` high ends any burst. `rdy` is low after the next active edge, and a strobe is ignored while `ce_n` is high.
- R11: A strobe during a running burst abandons that burst and starts a new one from the new address, following R2.
- R12: With `edge_fall` = 0 the logic advances on rising clock edges. With `edge_fall` = 1 it advances on falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low; returns to asynchronous mode |
| edge_fall | input | 1 | 0: rising edge active, 1: falling edge active |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Start address, sampled with the strobe |
| cfg_wr | input | 1 | Configuration-write pulse that enables burst mode |
| cfg_mode | input | 2 | 0 continuous, 1 wrap-8, 2 wrap-16, 3 wrap-32 |
| cfg_wait | input | WW | Base initial wait cycles |
| hs_en | input | 1 | Handshaking enable for boundary and start-offset latency |
| rd_addr | output | AW | Array read address |
| rdy | output | 1 | High while the current word is valid |

## Verification
The bench targets the edges of a 64-word block. It starts at offsets 3Ah, 3Dh, 3Eh and 3Fh with handshaking on and at 3Ch with it off. A design that counts extra cycles wrongly, or applies the skip rule to the wrong offsets, shifts the whole stream by a cycle or stalls where it should not. Wrap bursts are run across the 3Fh edge and to the 128-word limit: a wrong group mask leaks out of the group, and a wrong cap keeps `rdy` high or drops it early. The remaining cases cover the address roll-over at the top of the array, the strobe before the configuration write, a mid-burst restart, a chip-enable stop with a strobe pending, and falling-edge clocking. Each of these exposes a mode flag or edge select that is not wired through.

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq #(
  parameter int AW  = 22,
  parameter int WW  = 4,
  parameter int CAP = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_fall,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_mode,
  input  logic [WW-1:0] cfg_wait,
  input  logic          hs_en,
  output logic [AW-1:0] rd_addr,
  output logic          rdy
);
  localparam int TW = WW + 1;
  localparam int CW = $clog2(CAP + 1);
  localparam logic [5:0] TOP = 6'h3F;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DATA, S_BND} st_t;

  logic          eclk;
  logic          sync_q, hs_q, skip_q, bcnt_q, rdy_q;
  logic [1:0]    mode_q;
  st_t           st_q;
  logic [TW-1:0] wcnt_q, total;
  logic [CW-1:0] words_q;
  logic [AW-1:0] addr_q, gmask, wrap_nxt, inc_nxt;
  logic [5:0]    off;
  logic [1:0]    extra;

  assign eclk = clk ^ edge_fall;
  assign off  = addr_in[5:0];

  always_comb begin
    extra = 2'd0;
    if (hs_en) begin
      if (off == 6'h3D)      extra = 2'd1;
      else if (off == 6'h3E) extra = 2'd2;
      else if (off == 6'h3F) extra = 2'd3;
    end
  end

  assign total = {1'b0, cfg_wait} + {{(WW-1){1'b0}}, extra};

  always_comb begin
    case (mode_q)
      2'd1:    gmask = AW'(7);
      2'd2:    gmask = AW'(15);
      default: gmask = AW'(31);
    endcase
  end

  assign inc_nxt  = addr_q + 1'b1;
  assign wrap_nxt = (addr_q & ~gmask) | (inc_nxt & gmask);

  always_ff @(posedge eclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      st_q    <= S_IDLE;
      rdy_q   <= 1'b0;
      addr_q  <= '0;
      mode_q  <= 2'd0;
      hs_q    <= 1'b0;
      skip_q  <= 1'b0;
      bcnt_q  <= 1'b0;
      wcnt_q  <= '0;
      words_q <= '0;
    end else begin
      if (cfg_wr) sync_q <= 1'b1;
      if (ce_n) begin
        st_q  <= S_IDLE;
        rdy_q <= 1'b0;
      end else if (!adv_n && sync_q) begin
        addr_q  <= addr_in;
        mode_q  <= cfg_mode;
        hs_q    <= hs_en;
        skip_q  <= hs_en && (off >= 6'h3E);
        words_q <= CW'(1);
        wcnt_q  <= total;
        if (total == '0) begin
          st_q  <= S_DATA;
          rdy_q <= 1'b1;
        end else begin
          st_q  <= S_WAIT;
          rdy_q <= 1'b0;
        end
      end else begin
        case (st_q)
          S_WAIT: begin
            if (wcnt_q == TW'(1)) begin
              st_q  <= S_DATA;
              rdy_q <= 1'b1;
            end else begin
              wcnt_q <= wcnt_q - 1'b1;
            end
          end
          S_DATA: begin
            if (mode_q != 2'd0) begin
              if (words_q == CW'(CAP)) begin
                st_q  <= S_IDLE;
                rdy_q <= 1'b0;
              end else begin
                addr_q  <= wrap_nxt;
                words_q <= words_q + 1'b1;
              end
            end else if (addr_q[5:0] == TOP && hs_q && !skip_q) begin
              st_q   <= S_BND;
              rdy_q  <= 1'b0;
              bcnt_q <= 1'b1;
            end else begin
              addr_q <= inc_nxt;
              if (addr_q[5:0] == TOP) skip_q <= 1'b0;
            end
          end
          S_BND: begin
            if (!bcnt_q) begin
              addr_q <= inc_nxt;
              rdy_q  <= 1'b1;
              st_q   <= S_DATA;
            end else begin
              bcnt_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = addr_q;
  assign rdy     = rdy_q;
endmodule

// File: rtl/burst_seq_chk.sv
`timescale 1ns/1ps
module burst_seq_chk #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_fall,
  input logic          ce_n,
  input logic          adv_n,
  input logic          rdy,
  input logic [AW-1:0] rd_addr,
  input logic          sync_q,
  input logic [1:0]    mode_q
);
  logic eclk;
  assign eclk = clk ^ edge_fall;

  // R1: no valid data while still in asynchronous mode
  a_r1_async_quiet: assert property (@(posedge eclk) disable iff (!rst_n)
    !sync_q |-> !rdy);

  // R10: chip enable high ends the burst
  a_r10_ce_stop: assert property (@(posedge eclk) disable iff (!rst_n)
    ce_n |=> !rdy);

  // R3: continuous mode steps by one
  a_r3_cont_step: assert property (@(posedge eclk) disable iff (!rst_n)
    (rdy && $past(rdy) && $past(adv_n) && !$past(ce_n) && mode_q == 2'd0)
      |-> rd_addr == AW'($past(rd_addr) + 1'b1));

  // R4: wrap modes stay inside a 32-word aligned region
  a_r4_wrap_group: assert property (@(posedge eclk) disable iff (!rst_n)
    (rdy && $past(rdy) && $past(adv_n) && !$past(ce_n) && mode_q != 2'd0)
      |-> rd_addr[AW-1:5] == $past(rd_addr[AW-1:5]));

  // R6: a mid-burst stall in continuous mode only follows offset 3Fh
  a_r6_stall_at_top: assert property (@(posedge eclk) disable iff (!rst_n)
    ($past(rdy) && !rdy && $past(adv_n) && !$past(ce_n) && mode_q == 2'd0)
      |-> $past(rd_addr[5:0]) == 6'h3F);
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_fall(edge_fall), .ce_n(ce_n),
  .adv_n(adv_n), .rdy(rdy), .rd_addr(rd_addr), .sync_q(sync_q),
  .mode_q(mode_q)
);

// File: tb/burst_seq_tb.sv
`timescale 1ns/1ps
module burst_seq_tb;
  localparam int AW = 22;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          edge_fall = 1'b0;
  logic          ce_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_mode = 2'd0;
  logic [WW-1:0] cfg_wait = '0;
  logic          hs_en = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rdy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [AW+1:0] expq[$];
  string         tagq[$];

  always #4 clk = ~clk;

  burst_seq #(.AW(AW), .WW(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .edge_fall(edge_fall), .ce_n(ce_n),
    .adv_n(adv_n), .addr_in(addr_in), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_wait(cfg_wait), .hs_en(hs_en), .rd_addr(rd_addr), .rdy(rdy)
  );

  task automatic smp_edge();
    @(posedge clk or negedge clk);
    while (clk !== edge_fall) @(posedge clk or negedge clk);
  endtask

  task automatic tick();
    smp_edge();
    #1;
  endtask

  task automatic push(bit r, logic [AW-1:0] a, bit c, string t);
    expq.push_back({c, r, a});
    tagq.push_back(t);
  endtask

  // monitor: one expected item per active edge, checked at the opposite edge
  initial begin
    forever begin
      smp_edge();
      if (expq.size() > 0) begin
        logic [AW+1:0] it;
        string t;
        it = expq.pop_front();
        t  = tagq.pop_front();
        checks++;
        if (rdy !== it[AW] || (it[AW+1] && rd_addr !== it[AW-1:0])) begin
          fails++;
          $display("FAIL %s: rdy=%0b addr=%06h, expected rdy=%0b addr=%06h",
                   t, rdy, rd_addr, it[AW], it[AW-1:0]);
        end
      end
    end
  end

  task automatic run_burst(logic [AW-1:0] a0, logic [1:0] md, int wt, bit hs,
                           int ncyc, string t);
    int total, words, bleft;
    bit skip, fin;
    logic [AW-1:0] cur, mask;
    total = wt;
    if (hs && a0[5:0] == 6'h3D) total += 1;
    if (hs && a0[5:0] == 6'h3E) total += 2;
    if (hs && a0[5:0] == 6'h3F) total += 3;
    skip  = hs && (a0[5:0] >= 6'h3E);
    mask  = (md == 2'd0) ? '0 : AW'((8 << (md - 1)) - 1);
    cur = a0; words = 1; bleft = 0; fin = 1'b0;
    tick();
    ce_n = 1'b0; adv_n = 1'b0; addr_in = a0;
    cfg_mode = md; cfg_wait = WW'(wt); hs_en = hs;
    for (int k = 0; k < ncyc; k++) begin
      if (k < total) push(1'b0, a0, 1'b1, t);
      else if (k == total) push(1'b1, a0, 1'b1, t);
      else if (fin) push(1'b0, cur, 1'b1, t);
      else if (md != 2'd0) begin
        if (words == 128) begin
          fin = 1'b1;
          push(1'b0, cur, 1'b1, t);
        end else begin
          cur = (cur & ~mask) | ((cur + 1'b1) & mask);
          words++;
          push(1'b1, cur, 1'b1, t);
        end
      end else if (bleft > 0) begin
        bleft--;
        if (bleft == 0) begin
          cur = cur + 1'b1;
          push(1'b1, cur, 1'b1, t);
        end else push(1'b0, cur, 1'b1, t);
      end else if (cur[5:0] == 6'h3F && hs && !skip) begin
        bleft = 2;
        push(1'b0, cur, 1'b1, t);
      end else begin
        if (cur[5:0] == 6'h3F) skip = 1'b0;
        cur = cur + 1'b1;
        push(1'b1, cur, 1'b1, t);
      end
    end
    tick();
    adv_n = 1'b1;
    wait (expq.size() == 0);
  endtask

  task automatic do_cfg();
    tick();
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R1: reset state
    push(1'b0, '0, 1'b1, "R1 reset");
    push(1'b0, '0, 1'b1, "R1 reset");
    wait (expq.size() == 0);

    // R1: strobe ignored before the configuration write
    tick();
    ce_n = 1'b0; adv_n = 1'b0; addr_in = 22'h000123; cfg_wait = '0;
    for (int i = 0; i < 4; i++) push(1'b0, '0, 1'b1, "R1 async ignore");
    tick();
    adv_n = 1'b1;
    wait (expq.size() == 0);

    do_cfg();

    // R7 + R2: no handshake, crossing 3Fh without a stall
    run_burst(22'h00003C, 2'd0, 2, 1'b0, 12, "R7 no stall");
    // R2: zero wait
    run_burst(22'h000010, 2'd0, 0, 1'b0, 4, "R2 zero wait");
    // R6: handshake stall at the block top
    run_burst(22'h00017A, 2'd0, 1, 1'b1, 14, "R6 boundary stall");
    // R8: offset 3Dh adds one cycle, R6 stall still applies
    run_burst(22'h0000FD, 2'd0, 2, 1'b1, 12, "R8 offset 3D");
    // R8 + R9: offset 3Eh, two extra cycles and no stall
    run_burst(22'h0002BE, 2'd0, 1, 1'b1, 10, "R9 offset 3E");
    // R8 + R9: offset 3Fh, three extra cycles and no stall
    run_burst(22'h00003F, 2'd0, 0, 1'b1, 9, "R9 offset 3F");
    // R4: wrap of 8 from 39h
    run_burst(22'h000039, 2'd1, 1, 1'b0, 20, "R4 wrap8");
    // R4: wrap of 16
    run_burst(22'h000125, 2'd2, 0, 1'b0, 24, "R4 wrap16");
    // R4 + R6: wrap of 32 from 3Eh with handshake, no stall in the wrap
    run_burst(22'h00003E, 2'd3, 0, 1'b1, 40, "R4 wrap32");
    // R3: roll-over at the top of the array
    run_burst(22'h3FFFFD, 2'd0, 0, 1'b0, 8, "R3 rollover");
    // R5: 128-word wrap cap
    run_burst(22'h001234, 2'd1, 0, 1'b0, 132, "R5 wrap cap");
    // R11: restart during a running burst
    run_burst(22'h000500, 2'd0, 3, 1'b0, 6, "R11 first");
    run_burst(22'h000077, 2'd2, 0, 1'b0, 8, "R11 restart");

    // R10: chip enable high stops output, strobe ignored
    tick();
    ce_n = 1'b1; adv_n = 1'b0; addr_in = 22'h000ABC;
    for (int i = 0; i < 4; i++) push(1'b0, '0, 1'b0, "R10 ce stop");
    tick();
    adv_n = 1'b1;
    wait (expq.size() == 0);

    // R12: falling edge active
    tick();
    rst_n = 1'b0;
    tick();
    edge_fall = 1'b1;
    tick();
    rst_n = 1'b1;
    push(1'b0, '0, 1'b1, "R12 reset");
    wait (expq.size() == 0);
    do_cfg();
    run_burst(22'h00003B, 2'd0, 1, 1'b1, 10, "R12 falling edge");

    repeat (2) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule